// File: doc/BRIEF.md
# Double-Buffered Asynchronous Serial Transmitter

This block is the transmit side of an asynchronous serial port. It faces a host that writes characters in parallel. The host polls a status word for a "holding buffer empty" bit. When that bit is set, the host drives a character on the parallel data input and pulses a write strobe, and the character is captured into a holding register. A separate frame shift register sends characters out on the serial line. When that register has finished (or is on the final bit of) its current frame, the waiting character moves across on a bit-rate enable. As a result, the host can queue the next character while the current one is still leaving the line, and consecutive characters follow each other without an idle gap.

When a character moves across, framing logic wraps it with a low start bit, 5 to 8 data bits sent least significant bit first, an optional even or odd parity bit, and one or two high stop bits. The configuration inputs are sampled at that moment. The serial line advances one bit per pulse of an externally generated bit-rate enable, and it rests high whenever nothing is being sent. The status word appears on the status output only while the status enable input is high.

Top module: `uart_txd_dbuf`

## Requirements
- R1: While reset is asserted and directly after it, `txd_o` is 1, the holding register is empty and the frame register is idle.
- R2: A strobe accepted while the holding register is empty makes status bit 0 (holding empty) read 0 from the next clock cycle.
- R3: A strobe received while the holding register is full is ignored: the stored character is not replaced and no extra frame is sent.
- R4: A queued character moves into the frame register only on a clock edge where `bit_en_i` is high and the frame register is idle or on its final bit. Holding empty reads 1 from the cycle after that edge.
- R5: A frame is a start bit of 0, then N data bits least significant bit first (N = 5 + `cfg_len_i`), then optional parity, then stop bits of 1. The configuration in effect at the moment of transfer is used.
- R6: `cfg_par_i` encoding: 2'b01 adds an even parity bit (the data plus parity hold an even number of ones), 2'b10 adds an odd parity bit, and 2'b00 and 2'b11 add no parity bit.
- R7: `cfg_stop2_i` = 0 gives one stop bit and 1 gives two stop bits.
- R8: Each frame bit is driven from the edge after one `bit_en_i` pulse until the edge after the next pulse, so `txd_o` changes only after a `bit_en_i` cycle.
- R9: If a character is already waiting when the last stop bit ends, its start bit follows at once, with no idle bit in between.
- R10: `txd_o` is 1 whenever no frame is being sent.
- R11: With `stat_en_i` high, `stat_o` is {zeros, line idle in bit 1, holding empty in bit 0}. With `stat_en_i` low, `stat_o` is all zeros.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| bit_en_i | input | 1 | One-cycle pulse per serial bit period |
| tx_data_i | input | DATA_W | Character from the host |
| tx_stb_i | input | 1 | Write strobe for the holding register |
| stat_en_i | input | 1 | Puts the status word on `stat_o` |
| cfg_len_i | input | 2 | Data bits minus five |
| cfg_par_i | input | 2 | Parity mode |
| cfg_stop2_i | input | 1 | Selects two stop bits |
| txd_o | output | 1 | Serial line |
| stat_o | output | DATA_W | Status word, gated by `stat_en_i` |

## Verification
The holding-empty bit goes low one cycle after an accepted strobe, so the bench reads it at the next falling edge. It goes high again one cycle after the `bit_en_i` edge that performs the transfer, so the bench reads it at the falling edge of the pulse cycle (still 0) and again one cycle later (now 1). Serial bits are sampled at the falling edge of each `bit_en_i` cycle, which is the last point at which the current bit is valid. The first such sample after a transfer must be the start bit. Back-to-back frames are checked by requiring a start bit on the very next sample after the last stop bit.

// File: rtl/uart_txd_pkg.sv
package uart_txd_pkg;

  typedef enum logic [1:0] {
    PAR_OFF   = 2'b00,
    PAR_EVEN  = 2'b01,
    PAR_ODD   = 2'b10,
    PAR_OFF_B = 2'b11
  } par_mode_e;

  // Bits other than data: start, parity, two stops at most.
  localparam int FRAME_OVERHEAD = 4;

endpackage

// File: rtl/uart_txd_hold.sv
module uart_txd_hold #(
  parameter int DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_i,
  input  logic [DATA_W-1:0] data_i,
  input  logic              take_i,
  output logic              full_o,
  output logic [DATA_W-1:0] data_o
);

  logic              full_q, full_n;
  logic [DATA_W-1:0] data_q, data_n;
  logic              accept;

  assign accept = wr_i && !full_q;

  always_comb begin
    full_n = full_q;
    data_n = data_q;
    if (accept) begin
      full_n = 1'b1;
      data_n = data_i;
    end else if (take_i) begin
      full_n = 1'b0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      full_q <= 1'b0;
      data_q <= '0;
    end else begin
      full_q <= full_n;
      if (accept) begin
        data_q <= data_n;
      end
    end
  end

  assign full_o = full_q;
  assign data_o = data_q;

  AST_HOLD_IGNORE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (full_q && wr_i) |=> (data_q == $past(data_q))); // R3
  AST_HOLD_TAKE_FULL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    take_i |-> full_q); // R4
  AST_HOLD_FREED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    take_i |=> !full_q); // R4

endmodule

// File: rtl/uart_txd_frame.sv
module uart_txd_frame
  import uart_txd_pkg::*;
#(
  parameter int DATA_W  = 8,
  parameter int FRAME_W = DATA_W + FRAME_OVERHEAD,
  parameter int CNT_W   = $clog2(FRAME_W + 1)
) (
  input  logic [DATA_W-1:0]  data_i,
  input  logic [1:0]         cfg_len_i,
  input  logic [1:0]         cfg_par_i,
  input  logic               cfg_stop2_i,
  output logic [FRAME_W-1:0] frame_o,
  output logic [CNT_W-1:0]   len_o
);

  localparam int MIN_W = DATA_W - 3;

  par_mode_e mode;
  int        nbits;
  int        total;
  logic      par_en;
  logic      ones;
  logic      par_bit;

  always_comb begin
    mode   = par_mode_e'(cfg_par_i);
    nbits  = MIN_W + int'(cfg_len_i);
    par_en = (mode == PAR_EVEN) || (mode == PAR_ODD);
    ones   = 1'b0;
    for (int i = 0; i < DATA_W; i++) begin
      if (i < nbits) begin
        ones = ones ^ data_i[i];
      end
    end
    par_bit = (mode == PAR_ODD) ? ~ones : ones;

    // Unused positions stay 1 so stop bits and the idle tail are high.
    frame_o    = '1;
    frame_o[0] = 1'b0;
    for (int j = 1; j <= DATA_W; j++) begin
      if (j <= nbits) begin
        frame_o[j] = data_i[j-1];
      end
    end
    for (int k = 1; k < FRAME_W; k++) begin
      if (par_en && (k == nbits + 1)) begin
        frame_o[k] = par_bit;
      end
    end

    total = 2 + nbits + int'(par_en) + int'(cfg_stop2_i);
    len_o = CNT_W'(total);
  end

endmodule

// File: rtl/uart_txd_shift.sv
module uart_txd_shift #(
  parameter int FRAME_W = 12,
  parameter int CNT_W   = $clog2(FRAME_W + 1)
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               bit_en_i,
  input  logic               avail_i,
  input  logic [FRAME_W-1:0] frame_i,
  input  logic [CNT_W-1:0]   len_i,
  output logic               take_o,
  output logic               idle_o,
  output logic               txd_o
);

  logic [FRAME_W-1:0] sh_q, sh_n;
  logic [CNT_W-1:0]   cnt_q, cnt_n;
  logic               busy_q, busy_n;
  logic               last_bit;
  logic               end_of_char;

  assign last_bit    = busy_q && (cnt_q == CNT_W'(1));
  assign end_of_char = !busy_q || last_bit;
  assign take_o      = bit_en_i && end_of_char && avail_i;

  always_comb begin
    sh_n   = sh_q;
    cnt_n  = cnt_q;
    busy_n = busy_q;
    if (bit_en_i) begin
      if (take_o) begin
        sh_n   = frame_i;
        cnt_n  = len_i;
        busy_n = 1'b1;
      end else if (last_bit) begin
        sh_n   = '1;
        cnt_n  = '0;
        busy_n = 1'b0;
      end else if (busy_q) begin
        sh_n  = {1'b1, sh_q[FRAME_W-1:1]};
        cnt_n = cnt_q - CNT_W'(1);
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sh_q   <= '1;
      cnt_q  <= '0;
      busy_q <= 1'b0;
    end else if (bit_en_i) begin
      sh_q   <= sh_n;
      cnt_q  <= cnt_n;
      busy_q <= busy_n;
    end
  end

  assign txd_o  = busy_q ? sh_q[0] : 1'b1;
  assign idle_o = !busy_q;

  AST_START_BIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    take_o |=> !txd_o); // R5
  AST_LEN_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    take_o |-> ((len_i >= CNT_W'(2)) && (len_i <= CNT_W'(FRAME_W)))); // R7
  AST_BIT_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !bit_en_i |=> $stable(txd_o)); // R8
  AST_IDLE_AFTER_STOP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bit_en_i && last_bit && !avail_i) |=> (txd_o && idle_o)); // R10
  AST_BACK_TO_BACK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bit_en_i && last_bit && avail_i) |=> (!txd_o && !idle_o)); // R9

endmodule

// File: rtl/uart_txd_dbuf.sv
module uart_txd_dbuf
  import uart_txd_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              bit_en_i,
  input  logic [DATA_W-1:0] tx_data_i,
  input  logic              tx_stb_i,
  input  logic              stat_en_i,
  input  logic [1:0]        cfg_len_i,
  input  logic [1:0]        cfg_par_i,
  input  logic              cfg_stop2_i,
  output logic              txd_o,
  output logic [DATA_W-1:0] stat_o
);

  localparam int FRAME_W = DATA_W + FRAME_OVERHEAD;
  localparam int CNT_W   = $clog2(FRAME_W + 1);

  // Reset asserts at once and is released on a clock edge.
  logic [1:0] rst_sync_q;
  logic       rst_n;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rst_sync_q <= 2'b00;
    end else begin
      rst_sync_q <= {rst_sync_q[0], 1'b1};
    end
  end

  assign rst_n = rst_sync_q[1];

  logic               hold_full;
  logic [DATA_W-1:0]  hold_data;
  logic               take;
  logic               line_idle;
  logic [FRAME_W-1:0] frame;
  logic [CNT_W-1:0]   frame_len;

  uart_txd_hold #(.DATA_W(DATA_W)) u_hold (
    .clk_i  (clk_i),
    .rst_ni (rst_n),
    .wr_i   (tx_stb_i),
    .data_i (tx_data_i),
    .take_i (take),
    .full_o (hold_full),
    .data_o (hold_data)
  );

  uart_txd_frame #(
    .DATA_W  (DATA_W),
    .FRAME_W (FRAME_W),
    .CNT_W   (CNT_W)
  ) u_frame (
    .data_i      (hold_data),
    .cfg_len_i   (cfg_len_i),
    .cfg_par_i   (cfg_par_i),
    .cfg_stop2_i (cfg_stop2_i),
    .frame_o     (frame),
    .len_o       (frame_len)
  );

  uart_txd_shift #(
    .FRAME_W (FRAME_W),
    .CNT_W   (CNT_W)
  ) u_shift (
    .clk_i    (clk_i),
    .rst_ni   (rst_n),
    .bit_en_i (bit_en_i),
    .avail_i  (hold_full),
    .frame_i  (frame),
    .len_i    (frame_len),
    .take_o   (take),
    .idle_o   (line_idle),
    .txd_o    (txd_o)
  );

  always_comb begin
    stat_o = '0;
    if (stat_en_i) begin
      stat_o[0] = !hold_full;
      stat_o[1] = line_idle;
    end
  end

  AST_IDLE_LINE_HIGH: assert property (@(posedge clk_i) disable iff (!rst_n)
    line_idle |-> txd_o); // R10
  AST_STROBE_FILLS: assert property (@(posedge clk_i) disable iff (!rst_n)
    (tx_stb_i && !hold_full) |=> hold_full); // R2

endmodule

// File: tb/uart_txd_dbuf_test.sv
module uart_txd_dbuf_test;

  localparam int TICK_DIV = 8;

  typedef struct packed {
    logic [7:0] ch;
    logic [1:0] len;
    logic [1:0] par;
    logic       stop2;
  } vec_t;

  localparam vec_t VECS [9] = '{
    '{8'hA5, 2'd3, 2'd0, 1'b0},
    '{8'h3C, 2'd3, 2'd1, 1'b0},
    '{8'h3C, 2'd3, 2'd2, 1'b1},
    '{8'h1F, 2'd0, 2'd1, 1'b1},
    '{8'h15, 2'd1, 2'd2, 1'b0},
    '{8'h7F, 2'd2, 2'd1, 1'b1},
    '{8'hFF, 2'd0, 2'd0, 1'b0},
    '{8'h00, 2'd3, 2'd2, 1'b1},
    '{8'h80, 2'd3, 2'd3, 1'b0}
  };

  logic       clk = 1'b0;
  logic       rst_n;
  logic       bit_en;
  logic [7:0] data;
  logic       stb;
  logic       stat_en;
  logic [1:0] clen;
  logic [1:0] cpar;
  logic       stop2;
  wire        txd;
  wire  [7:0] stat;

  int checks = 0;
  int errors = 0;

  always #10 clk = ~clk;

  uart_txd_dbuf #(.DATA_W(8)) uut (
    .clk_i       (clk),
    .rst_ni      (rst_n),
    .bit_en_i    (bit_en),
    .tx_data_i   (data),
    .tx_stb_i    (stb),
    .stat_en_i   (stat_en),
    .cfg_len_i   (clen),
    .cfg_par_i   (cpar),
    .cfg_stop2_i (stop2),
    .txd_o       (txd),
    .stat_o      (stat)
  );

  initial begin
    bit_en = 1'b0;
    forever begin
      repeat (TICK_DIV - 1) @(posedge clk);
      #1 bit_en = 1'b1;
      @(posedge clk);
      #1 bit_en = 1'b0;
    end
  end

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic int exp_frame(input vec_t v, output logic [11:0] bits);
    int n;
    int k;
    logic p;
    n = 5 + int'(v.len);
    bits = '1;
    bits[0] = 1'b0;
    k = 1;
    p = 1'b0;
    for (int i = 0; i < n; i++) begin
      bits[k] = v.ch[i];
      p = p ^ v.ch[i];
      k = k + 1;
    end
    if (v.par == 2'd1 || v.par == 2'd2) begin
      bits[k] = (v.par == 2'd2) ? ~p : p;
      k = k + 1;
    end
    bits[k] = 1'b1;
    k = k + 1;
    if (v.stop2) begin
      bits[k] = 1'b1;
      k = k + 1;
    end
    return k;
  endfunction

  task automatic tick_sample(output logic b);
    do @(negedge clk); while (!bit_en);
    b = txd;
  endtask

  task automatic write_char(input vec_t v);
    do @(negedge clk); while (!stat[0]);
    clen  = v.len;
    cpar  = v.par;
    stop2 = v.stop2;
    data  = v.ch;
    stb   = 1'b1;
    @(negedge clk);
    stb   = 1'b0;
  endtask

  task automatic recv_frame(input vec_t v, input bit strict, input string tag);
    logic [11:0] want;
    logic [11:0] got;
    logic b;
    int   len;
    len = exp_frame(v, want);
    got = '1;
    tick_sample(b);
    if (strict) begin
      chk(b == 1'b0, tag, b, 0);
    end else begin
      while (b != 1'b0) tick_sample(b);
    end
    got[0] = b;
    for (int i = 1; i < len; i++) begin
      tick_sample(b);
      got[i] = b;
    end
    chk(got == want, "R5/R6/R7 frame bits", got, want);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic b;
    int   zeros;
    vec_t vx;
    vec_t vy;
    rst_n   = 1'b0;
    stb     = 1'b0;
    stat_en = 1'b0;
    data    = 8'h00;
    clen    = 2'd3;
    cpar    = 2'd0;
    stop2   = 1'b0;
    repeat (3) @(negedge clk);
    chk(txd == 1'b1, "R1 txd in reset", txd, 1);
    chk(stat == 8'h00, "R11 stat gated low", stat, 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk(txd == 1'b1, "R10 idle after reset", txd, 1);
    stat_en = 1'b1;
    #1;
    chk(stat == 8'h03, "R1 reset status", stat, 8'h03);

    // Table: the writer queues each character as soon as the holding register frees up.
    fork
      begin
        for (int i = 0; i < 9; i++) write_char(VECS[i]);
      end
      begin
        for (int i = 0; i < 9; i++) recv_frame(VECS[i], i > 0, "R9 no gap before start");
      end
    join

    tick_sample(b);
    chk(b == 1'b1, "R10 idle after last frame", b, 1);
    @(negedge clk);
    chk(stat == 8'h03, "R11 status idle", stat, 8'h03);

    // Transfer timing (R2, R4) plus a strobe into a full register (R3).
    vx = '{8'h5A, 2'd3, 2'd1, 1'b0};
    vy = '{8'hC3, 2'd2, 2'd2, 1'b1};
    tick_sample(b);
    @(negedge clk);
    clen = vx.len; cpar = vx.par; stop2 = vx.stop2; data = vx.ch;
    stb = 1'b1;
    @(negedge clk);
    stb = 1'b0;
    chk(stat == 8'h02, "R2 holding full after strobe", stat, 8'h02);
    do @(negedge clk); while (!bit_en);
    chk(stat == 8'h02, "R4 no transfer before bit edge", stat, 8'h02);
    @(negedge clk);
    chk(stat == 8'h01, "R4 transfer at bit edge", stat, 8'h01);
    clen = vy.len; cpar = vy.par; stop2 = vy.stop2; data = vy.ch;
    stb = 1'b1;
    @(negedge clk);
    stb = 1'b0;
    chk(stat == 8'h00, "R11 busy and full", stat, 8'h00);
    data = 8'hE7;
    stb  = 1'b1;
    @(negedge clk);
    stb  = 1'b0;
    stat_en = 1'b0;
    #1;
    chk(stat == 8'h00, "R11 gated while busy", stat, 8'h00);
    stat_en = 1'b1;
    recv_frame(vx, 1'b1, "R8 start on first bit after transfer");
    recv_frame(vy, 1'b1, "R3 stored character kept");
    zeros = 0;
    for (int i = 0; i < 14; i++) begin
      tick_sample(b);
      if (b == 1'b0) zeros++;
    end
    chk(zeros == 0, "R3 ignored strobe sent nothing", zeros, 0);
    @(negedge clk);
    chk(stat == 8'h03, "R10 idle status at end", stat, 8'h03);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule